// File: doc/BRIEF.md
# Aging Blocked-Task Release Selector

This block keeps a small store of tasks that wait on a shared resource. Each stored task has an identifier, a processing priority and an aging count. When the resource becomes free, the requester pulses a release request. The block then scores every stored task whose aging count is above a programmable threshold. The score is the processing priority times the aging count. The block takes out the task with the largest score and ages every task that stays behind. Aging prevents a low-priority task from starving.

A released task is written into a small waiting FIFO. The downstream arrival queue drains that FIFO in release order. The store and the FIFO are both fully registered: a release or insert seen at a clock edge is visible on the outputs right after that edge.

Top module: `brs_release_sel`

## Requirements
- R1: An insert (`ins_valid` high) while the store is not full places the task in the lowest-numbered free slot with an aging count of 1. It is not aged by a release at the same edge, and it does not take the slot freed by that release.
- R2: `store_full` is high exactly while all DEPTH slots (default 8) hold a task. An insert while the store is full is refused and the store is left unchanged.
- R3: A stored task is eligible only when its aging count is strictly greater than `age_thresh`.
- R4: On an acted-on release, the eligible task with the largest product of processing priority and aging count leaves the store. On equal products the lowest slot index wins. `rel_valid` pulses for one cycle after the request edge, with that task's identifier on `rel_id`.
- R5: After each release that moves a task, every task left in the store has its aging count raised by 1. The count saturates at 2^AGE_W-1 (15 by default) and does not wrap.
- R6: If no task is eligible when a release is acted on, no task moves and no count changes. `no_cand` pulses for one cycle after the request edge.
- R7: Released identifiers leave on `wq_id` in release order. `wq_valid` is high while the waiting FIFO is not empty. `wq_pop` removes the head and has no effect on an empty FIFO.
- R8: A release request while the waiting FIFO is full is ignored entirely. No task moves, no count changes, and neither `rel_valid` nor `no_cand` is raised.
- R9: After reset the store and the FIFO are empty, and `rel_valid`, `no_cand`, `store_full` and `wq_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | 1 | Insert a blocked task |
| ins_id | input | ID_W | Identifier of the inserted task |
| ins_prio | input | PRIO_W | Processing priority of the inserted task |
| age_thresh | input | AGE_W | Eligibility threshold for aging counts |
| rel_req | input | 1 | Resource became free: release one task |
| rel_valid | output | 1 | One-cycle pulse: a task was released |
| rel_id | output | ID_W | Identifier of the released task |
| no_cand | output | 1 | One-cycle pulse: release found no eligible task |
| store_full | output | 1 | All store slots are occupied |
| wq_valid | output | 1 | Waiting FIFO holds at least one identifier |
| wq_id | output | ID_W | Head of the waiting FIFO |
| wq_pop | input | 1 | Arrival queue takes the head |

## Verification
A release or no-candidate result is due one edge after the request: `rel_valid`, `rel_id` and `no_cand` are read in the low phase that follows that edge. A FIFO write and a pop take effect at the same edge, so `wq_valid` and `wq_id` reflect them in that same low phase. `store_full` after an insert or release is also due one edge later. The bench drives inputs in the low phase and advances its reference model by exactly one step per edge. It compares every output once per cycle, so no result is read a cycle early or late.

// File: rtl/brs_pkg.sv
package brs_pkg;
    localparam int ID_W   = 4;
    localparam int PRIO_W = 4;
    localparam int AGE_W  = 4;
    localparam int SCORE_W = PRIO_W + AGE_W;

    typedef logic [ID_W-1:0]    id_t;
    typedef logic [PRIO_W-1:0]  prio_t;
    typedef logic [AGE_W-1:0]   age_t;
    typedef logic [SCORE_W-1:0] score_t;

    localparam age_t AGE_MAX = '1;

    typedef struct packed {
        logic  vld;
        id_t   id;
        prio_t prio;
        age_t  age;
    } slot_t;
endpackage

// File: rtl/brs_unload_calc.sv
module brs_unload_calc
    import brs_pkg::*;
(
    input  slot_t  slot,
    input  age_t   thresh,
    output logic   eligible,
    output score_t score
);
    always_comb begin
        eligible = slot.vld && (slot.age > thresh);
        score    = SCORE_W'(slot.prio) * SCORE_W'(slot.age);
    end
endmodule

// File: rtl/brs_pick.sv
module brs_pick
    import brs_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]         elig,
    input  logic [DEPTH*SCORE_W-1:0] scores,
    output logic                     found,
    output logic [IDX_W-1:0]         idx
);
    score_t best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (elig[i] && (!found || scores[i*SCORE_W +: SCORE_W] > best)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = scores[i*SCORE_W +: SCORE_W];
            end
        end
    end
endmodule

// File: rtl/brs_wait_fifo.sv
module brs_wait_fifo
    import brs_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1,
    localparam int CNT_W = PTR_W + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  id_t  push_id,
    input  logic pop,
    output logic valid,
    output id_t  head,
    output logic full
);
    typedef struct packed {
        id_t [FIFO_DEPTH-1:0] mem;
        logic [PTR_W-1:0]     rd_ptr;
        logic [PTR_W-1:0]     wr_ptr;
        logic [CNT_W-1:0]     cnt;
    } fifo_t;

    fifo_t q, d;
    logic do_pop, do_push;

    always_comb begin
        d       = q;
        do_pop  = pop && (q.cnt != '0);
        do_push = push && (q.cnt != CNT_W'(FIFO_DEPTH));
        if (do_push) begin
            d.mem[q.wr_ptr] = push_id;
            d.wr_ptr = (q.wr_ptr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : q.wr_ptr + 1'b1;
        end
        if (do_pop) begin
            d.rd_ptr = (q.rd_ptr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : q.rd_ptr + 1'b1;
        end
        d.cnt = q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign valid = (q.cnt != '0);
    assign head  = q.mem[q.rd_ptr];
    assign full  = (q.cnt == CNT_W'(FIFO_DEPTH));
endmodule

// File: rtl/brs_release_sel.sv
module brs_release_sel
    import brs_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int FIFO_DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [ID_W-1:0]   ins_id,
    input  logic [PRIO_W-1:0] ins_prio,
    input  logic [AGE_W-1:0]  age_thresh,
    input  logic              rel_req,
    output logic              rel_valid,
    output logic [ID_W-1:0]   rel_id,
    output logic              no_cand,
    output logic              store_full,
    output logic              wq_valid,
    output logic [ID_W-1:0]   wq_id,
    input  logic              wq_pop
);
    typedef struct packed {
        slot_t [DEPTH-1:0] slots;
        logic              rel_vld;
        id_t               rel_id;
        logic              no_cand;
    } state_t;

    state_t q, d;

    logic [DEPTH-1:0]         elig;
    logic [DEPTH*SCORE_W-1:0] scores;
    logic                     found;
    logic [IDX_W-1:0]         pick;
    logic                     fifo_full;
    logic                     rel_go;
    logic                     push;
    logic [DEPTH-1:0]         occ_vec;
    logic [OCC_W-1:0]         occ;
    logic [IDX_W-1:0]         free_idx;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_calc
            score_t sc;
            brs_unload_calc u_calc (
                .slot     (q.slots[g]),
                .thresh   (age_thresh),
                .eligible (elig[g]),
                .score    (sc)
            );
            assign scores[g*SCORE_W +: SCORE_W] = sc;
            assign occ_vec[g] = q.slots[g].vld;
        end
    endgenerate

    brs_pick #(.DEPTH(DEPTH)) u_pick (
        .elig   (elig),
        .scores (scores),
        .found  (found),
        .idx    (pick)
    );

    always_comb begin
        occ      = OCC_W'($countones(occ_vec));
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!occ_vec[i]) free_idx = IDX_W'(i);
        end
    end

    assign store_full = &occ_vec;
    assign rel_go     = rel_req && !fifo_full;
    assign push       = rel_go && found;

    always_comb begin
        d         = q;
        d.rel_vld = 1'b0;
        d.no_cand = 1'b0;
        if (rel_go) begin
            if (found) begin
                d.rel_vld = 1'b1;
                d.rel_id  = q.slots[pick].id;
                for (int i = 0; i < DEPTH; i++) begin
                    if (IDX_W'(i) == pick) begin
                        d.slots[i].vld = 1'b0;
                    end else if (q.slots[i].vld && q.slots[i].age != AGE_MAX) begin
                        d.slots[i].age = q.slots[i].age + 1'b1;
                    end
                end
            end else begin
                d.no_cand = 1'b1;
            end
        end
        if (ins_valid && !store_full) begin
            d.slots[free_idx].vld  = 1'b1;
            d.slots[free_idx].id   = ins_id;
            d.slots[free_idx].prio = ins_prio;
            d.slots[free_idx].age  = age_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    brs_wait_fifo #(.FIFO_DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .push_id (q.slots[pick].id),
        .pop     (wq_pop),
        .valid   (wq_valid),
        .head    (wq_id),
        .full    (fifo_full)
    );

    assign rel_valid = q.rel_vld;
    assign rel_id    = q.rel_id;
    assign no_cand   = q.no_cand;
endmodule

// File: rtl/brs_release_sel_chk.sv
module brs_release_sel_chk #(
    parameter int DEPTH = 8,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rel_req,
    input logic             rel_valid,
    input logic             no_cand,
    input logic             store_full,
    input logic             wq_valid,
    input logic             fifo_full,
    input logic [OCC_W-1:0] occ
);
    AST_REL_NOCAND_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rel_valid && no_cand)); // R6
    AST_REL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) rel_valid |-> $past(rel_req)); // R4
    AST_NOCAND_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) no_cand |-> $past(rel_req)); // R6
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (store_full && !rel_req) |=> store_full); // R2
    AST_RELEASE_QUEUED: assert property (@(posedge clk) disable iff (!rst_n) rel_valid |-> wq_valid); // R7
    AST_FIFO_FULL_IGNORES: assert property (@(posedge clk) disable iff (!rst_n) (rel_req && fifo_full) |=> (!rel_valid && !no_cand)); // R8
    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n) occ <= OCC_W'(DEPTH)); // R2
endmodule

bind brs_release_sel brs_release_sel_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rel_req    (rel_req),
    .rel_valid  (rel_valid),
    .no_cand    (no_cand),
    .store_full (store_full),
    .wq_valid   (wq_valid),
    .fifo_full  (fifo_full),
    .occ        (occ)
);

// File: tb/brs_release_sel_test.sv
module brs_release_sel_test;
    localparam int DEPTH = 8;
    localparam int FD    = 8;
    localparam int AMAX  = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ins_valid = 1'b0;
    logic [3:0] ins_id = '0, ins_prio = '0, age_thresh = '0;
    logic rel_req = 1'b0, wq_pop = 1'b0;
    logic rel_valid, no_cand, store_full, wq_valid;
    logic [3:0] rel_id, wq_id;

    int errors = 0, checks = 0;
    bit done = 0;

    // reference model
    bit m_v[DEPTH];
    int m_id[DEPTH], m_pr[DEPTH], m_age[DEPTH];
    int m_fifo[FD];
    int m_fcnt = 0;
    bit e_rel = 0, e_nc = 0;
    int e_rid = 0;

    always #10 clk = ~clk;

    brs_release_sel uut (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_id(ins_id),
        .ins_prio(ins_prio), .age_thresh(age_thresh), .rel_req(rel_req),
        .rel_valid(rel_valid), .rel_id(rel_id), .no_cand(no_cand),
        .store_full(store_full), .wq_valid(wq_valid), .wq_id(wq_id), .wq_pop(wq_pop)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int m_count();
        int c = 0;
        for (int i = 0; i < DEPTH; i++) c += m_v[i];
        return c;
    endfunction

    // one reference step for the inputs now applied (pre-edge state)
    function automatic void m_step();
        bit pre_v[DEPTH];
        bit full_pre = (m_count() == DEPTH);
        bit ffull = (m_fcnt == FD);
        bit pop_ok = wq_pop && (m_fcnt > 0);
        int best = -1, bs = 0, fi = -1;
        for (int i = 0; i < DEPTH; i++) pre_v[i] = m_v[i];
        e_rel = 0; e_nc = 0;
        if (rel_req && !ffull) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (m_v[i] && m_age[i] > int'(age_thresh)) begin
                    if (best < 0 || m_pr[i] * m_age[i] > bs) begin
                        best = i; bs = m_pr[i] * m_age[i];
                    end
                end
            end
            if (best >= 0) begin
                e_rel = 1; e_rid = m_id[best];
                m_v[best] = 0;
                for (int i = 0; i < DEPTH; i++)
                    if (m_v[i] && m_age[i] < AMAX) m_age[i]++;
            end else e_nc = 1;
        end
        if (ins_valid && !full_pre) begin
            for (int i = DEPTH - 1; i >= 0; i--) if (!pre_v[i]) fi = i;
            m_v[fi] = 1; m_id[fi] = ins_id; m_pr[fi] = ins_prio; m_age[fi] = 1;
        end
        if (pop_ok) begin
            for (int i = 0; i < FD - 1; i++) m_fifo[i] = m_fifo[i+1];
            m_fcnt--;
        end
        if (e_rel) begin
            m_fifo[m_fcnt] = e_rid; m_fcnt++;
        end
    endfunction

    task automatic cyc(bit iv, int id, int pr, bit rr, bit pp, int th);
        ins_valid = iv; ins_id = 4'(id); ins_prio = 4'(pr);
        rel_req = rr; wq_pop = pp; age_thresh = 4'(th);
        m_step();
        @(posedge clk); #5;
        check(rel_valid == e_rel, "R4 rel_valid", rel_valid, e_rel);
        if (e_rel) check(rel_id == 4'(e_rid), "R4/R5 rel_id", rel_id, e_rid);
        check(no_cand == e_nc, "R6/R8 no_cand", no_cand, e_nc);
        check(store_full == (m_count() == DEPTH), "R2 store_full", store_full, m_count() == DEPTH);
        check(wq_valid == (m_fcnt > 0), "R7 wq_valid", wq_valid, m_fcnt > 0);
        if (m_fcnt > 0) check(wq_id == 4'(m_fifo[0]), "R7 wq_id", wq_id, m_fifo[0]);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) begin m_v[i] = 0; m_age[i] = 0; m_id[i] = 0; m_pr[i] = 0; end
        repeat (3) @(posedge clk);
        #5;
        // R9: reset state
        check(!rel_valid && !no_cand, "R9 flags", rel_valid | no_cand, 0);
        check(!store_full, "R9 store_full", store_full, 0);
        check(!wq_valid, "R9 wq_valid", wq_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2: fill, ninth insert refused
        for (int k = 0; k < 9; k++) cyc(1, k, k + 1, 0, 0, 0);
        check(store_full == 1'b1, "R2 full after eight", store_full, 1);
        // R4: releases by score, no pops so the FIFO fills
        for (int k = 0; k < 8; k++) cyc(0, 0, 0, 1, 0, 0);
        // R8: release with FIFO full is ignored
        cyc(1, 9, 9, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        check(!rel_valid && !no_cand, "R8 ignored", rel_valid | no_cand, 0);
        for (int k = 0; k < 9; k++) cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 1, 1, 0);
        cyc(0, 0, 0, 0, 1, 0);
        // R7: pop on empty FIFO
        cyc(0, 0, 0, 0, 1, 0);
        check(!wq_valid, "R7 empty pop", wq_valid, 0);

        // R4: tie goes to lowest slot
        cyc(1, 3, 3, 0, 0, 0);
        cyc(1, 5, 3, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        check(rel_id == 4'd3, "R4 tie lowest slot", rel_id, 3);
        // R3/R6: threshold blocks release (remaining age is 2)
        cyc(0, 0, 0, 1, 1, 2);
        check(no_cand == 1'b1, "R3/R6 none eligible", no_cand, 1);
        cyc(0, 0, 0, 1, 1, 1);
        check(rel_id == 4'd5, "R3 eligible above threshold", rel_id, 5);
        cyc(0, 0, 0, 0, 1, 0);

        // R5: saturation of a zero-priority task left behind many times
        cyc(1, 7, 0, 0, 0, 0);
        for (int k = 0; k < 20; k++) begin
            cyc(1, 8, 15, 0, 1, 0);
            cyc(0, 0, 0, 1, 1, 0);
        end
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 1, 1, 14);
        check(rel_valid && rel_id == 4'd7, "R5 age saturated at 15", rel_id, 7);
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 1, 0);

        // constrained random traffic
        for (int k = 0; k < 4000; k++) begin
            int th = ($urandom % 4 == 0) ? int'($urandom % 4) : 0;
            cyc(($urandom % 2) == 0, int'($urandom % 16), int'($urandom % 16),
                ($urandom % 10) < 3, ($urandom % 10) < 4, th);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule